// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides what the core's clocks do when a sleep instruction retires. At that moment it samples an idle-enable bit and a 2-bit clock-select field and picks one of three low-power states. Full sleep stops the CPU clock, the peripheral clock and the primary oscillator. Primary idle stops only the CPU clock. Secondary idle stops the CPU clock and the primary oscillator, and the peripherals keep running from the secondary oscillator. Before the chosen state takes effect there is one cycle of entry, in which only the CPU clock is held.

A wake event ends the low-power state: an interrupt, a reset request or a watchdog timeout, all merged onto one `wake` input. From either idle state, execution resumes after a fixed settling delay of `TCSD_CYCLES` system clocks. From full sleep, the CPU waits for the selected clock source to become ready and then takes the same settling delay. A crystal primary source must first count its start-up cycles. When two-speed start-up is enabled, the CPU instead runs at once from the internal RC oscillator until the selected source is ready.

The block does not modify the idle bit or the clock-select field; both are plain inputs. `rst_n` is asynchronous and active-low. It must be released in step with `clk`.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, the controller is in run. `cpu_clk_en`, `per_clk_en` and `pri_osc_en` are 1, and `osc_stat` is 3'b000 until the primary start-up count completes.
- R2: The controller is in run when `sleep_req` is sampled. If `idle_en`=0 and `wake` is low, `cpu_clk_en` is 0 after that edge. After the next edge the controller is in full sleep: `cpu_clk_en`, `per_clk_en` and `pri_osc_en` are 0, `osc_stat` is 3'b000, and `rc_osc_en` equals `wdt_en`.
- R3: A sleep request with `idle_en`=1 and `clk_sel` of 2'b00, 2'b10 or 2'b11 enters primary idle. Here `cpu_clk_en`=0, while `per_clk_en`=1, `pri_osc_en`=1 and `osc_stat[0]` stay 1 if the primary source was already ready.
- R4: A sleep request with `idle_en`=1, `clk_sel`=2'b01 and `sec_osc_en`=1 enters secondary idle. Here `cpu_clk_en`=0, `per_clk_en`=1, `pri_osc_en`=0, and `osc_stat` is 3'b010 while `sec_osc_run`=1.
- R5: A sleep request for secondary idle while `sec_osc_en`=0 is ignored: `cpu_clk_en` stays 1 on every following cycle.
- R6: From either idle state, `cpu_clk_en` returns to 1 exactly `TCSD_CYCLES` edges after the edge that samples `wake`.
- R7: From full sleep with `fast_start`=0, the primary oscillator restarts. Its start-up takes `OST_CYCLES` edges for `osc_mode` 0, 1 or 2. It takes `OST_CYCLES`+`PLL_CYCLES` edges for code 3 (crystal with PLL). It takes 1 edge for codes 4 to 7. `cpu_clk_en` rises start-up+1+`TCSD_CYCLES` edges after the wake edge. With `clk_sel`=2'b01, `cpu_clk_en` instead waits for `sec_osc_run`.
- R8: From full sleep with `fast_start`=1, `cpu_clk_en`=1 and `osc_stat[2]`=1 right after the wake edge. `osc_stat[2]` clears one edge after the selected source becomes ready.
- R9: A `wake` sampled during the entry cycle aborts the entry. After that edge the controller is back in run with `cpu_clk_en`=1, and `pri_osc_en` never drops.
- R10: `wake` in run has no effect, and a `sleep_req` sampled together with `wake` is ignored: `cpu_clk_en` stays 1.
- R11: `osc_stat[0]` means the primary source is on and its start-up count is done. `osc_stat[1]` means the CPU-side clock comes from a running secondary oscillator (`clk_sel`=2'b01). `osc_stat[2]` means the CPU runs from the internal RC during a fast start. Bits 1 and 2 are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction retired this cycle |
| idle_en | input | 1 | 1 selects an idle state, 0 selects full sleep |
| clk_sel | input | 2 | 00 primary, 01 secondary, 1x treated as primary |
| sec_osc_en | input | 1 | Secondary oscillator enabled by software |
| sec_osc_run | input | 1 | Secondary oscillator running and stable |
| wdt_en | input | 1 | Watchdog enabled; keeps internal RC alive |
| fast_start | input | 1 | Two-speed start-up / fail-safe monitoring enabled |
| osc_mode | input | 3 | Primary oscillator type code (0..3 crystal, 3 with PLL) |
| wake | input | 1 | Merged wake event |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| osc_stat | output | 3 | Clock-source status: primary ready, secondary, internal |

## Verification
Every output is decoded from registered state, so each result is due a fixed number of edges after its stimulus. Entry shows one edge after `sleep_req`, and the sleep state one edge after that. An idle wake shows `TCSD_CYCLES` edges after `wake`. A full-sleep wake shows start-up + 1 + `TCSD_CYCLES` edges after `wake`, or 1 edge with a fast start. The bench changes inputs and samples outputs 1 ns after each rising edge. It counts the edges from the wake edge until `cpu_clk_en` rises, and compares that count with the figure it computes from `osc_mode`, `clk_sel` and `fast_start`. This is done over all eight oscillator codes and all clock-select values.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_SLP_FULL,
    ST_SLP_PIDLE,
    ST_SLP_SIDLE,
    ST_WAIT_SRC,
    ST_FAST,
    ST_DELAY
  } lpm_state_e;

  typedef enum logic [1:0] {
    TGT_FULL,
    TGT_PIDLE,
    TGT_SIDLE
  } lpm_target_e;

  localparam logic [1:0] SEL_SEC   = 2'b01;
  localparam logic [2:0] OSC_HSPLL = 3'd3;

  // codes 0..3 are crystal or resonator sources that need a start-up count
  function automatic logic osc_is_crystal(input logic [2:0] mode);
    return (mode <= OSC_HSPLL);
  endfunction

endpackage

// File: rtl/lpm_entry_decode.sv
module lpm_entry_decode
  import lpm_pkg::*;
(
  input  logic        idle_en,
  input  logic [1:0]  clk_sel,
  input  logic        sec_osc_en,
  output lpm_target_e target,
  output logic        target_ok
);

  always_comb begin
    target    = TGT_FULL;
    target_ok = 1'b1;
    if (idle_en) begin
      if (clk_sel == SEL_SEC) begin
        target    = TGT_SIDLE;
        target_ok = sec_osc_en;
      end else begin
        target    = TGT_PIDLE;
      end
    end
  end

endmodule

// File: rtl/lpm_startup_timer.sv
module lpm_startup_timer
  import lpm_pkg::*;
#(
  parameter int OST_CYCLES = 16,
  parameter int PLL_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_on,
  input  logic [2:0] osc_mode,
  output logic       ready
);

  localparam int TOTAL = OST_CYCLES + PLL_CYCLES;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;
  logic [CNT_W-1:0] pll_extra;
  logic [CNT_W-1:0] limit;

  generate
    if (PLL_CYCLES > 0) begin : g_pll
      assign pll_extra = (osc_mode == OSC_HSPLL) ? CNT_W'(PLL_CYCLES) : '0;
    end else begin : g_nopll
      assign pll_extra = '0;
    end
  endgenerate

  // last count value before ready; non-crystal sources are ready after one edge
  assign limit = osc_is_crystal(osc_mode)
               ? (CNT_W'(OST_CYCLES) + pll_extra - CNT_W'(1))
               : '0;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!osc_on) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q >= limit) begin
        rdy_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int TCSD_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_req,
  input  logic        wake,
  input  lpm_target_e target,
  input  logic        target_ok,
  input  logic        fast_start,
  input  logic        src_rdy,
  output lpm_state_e  state
);

  localparam int DLY_W = (TCSD_CYCLES > 1) ? $clog2(TCSD_CYCLES) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(TCSD_CYCLES - 1);

  lpm_state_e       st_q, st_d;
  lpm_target_e      tgt_q, tgt_d;
  logic [DLY_W-1:0] dly_q, dly_d;

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    dly_d = '0;
    case (st_q)
      ST_RUN: begin
        if (sleep_req && !wake && target_ok) begin
          st_d  = ST_ENTER;
          tgt_d = target;
        end
      end
      ST_ENTER: begin
        if (wake) begin
          st_d = ST_RUN;
        end else begin
          case (tgt_q)
            TGT_PIDLE: st_d = ST_SLP_PIDLE;
            TGT_SIDLE: st_d = ST_SLP_SIDLE;
            default:   st_d = ST_SLP_FULL;
          endcase
        end
      end
      ST_SLP_FULL: begin
        if (wake) st_d = fast_start ? ST_FAST : ST_WAIT_SRC;
      end
      ST_SLP_PIDLE, ST_SLP_SIDLE: begin
        if (wake) st_d = ST_DELAY;
      end
      ST_WAIT_SRC: begin
        if (src_rdy) st_d = ST_DELAY;
      end
      ST_FAST: begin
        if (src_rdy) st_d = ST_RUN;
      end
      ST_DELAY: begin
        if (dly_q == DLY_LAST) begin
          st_d = ST_RUN;
        end else begin
          dly_d = dly_q + DLY_W'(1);
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      tgt_q <= TGT_FULL;
      dly_q <= '0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      dly_q <= dly_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       wdt_en,
  input  logic       pri_rdy,
  input  logic [1:0] clk_sel,
  input  logic       sec_osc_run,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       pri_osc_en,
  output logic       rc_osc_en,
  output logic [2:0] osc_stat
);

  logic pri_on;
  logic on_sec;

  always_comb begin
    cpu_clk_en = (state == ST_RUN) || (state == ST_FAST);
    per_clk_en = !((state == ST_SLP_FULL) || (state == ST_WAIT_SRC));
    pri_on     = !((state == ST_SLP_FULL) || (state == ST_SLP_SIDLE));
    pri_osc_en = pri_on;
    rc_osc_en  = wdt_en || (state == ST_FAST);
    on_sec     = (clk_sel == SEL_SEC) && sec_osc_run &&
                 !((state == ST_SLP_FULL) || (state == ST_WAIT_SRC) ||
                   (state == ST_FAST));
    osc_stat   = {(state == ST_FAST), on_sec, (pri_rdy && pri_on)};
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int OST_CYCLES  = 16,
  parameter int PLL_CYCLES  = 8,
  parameter int TCSD_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       idle_en,
  input  logic [1:0] clk_sel,
  input  logic       sec_osc_en,
  input  logic       sec_osc_run,
  input  logic       wdt_en,
  input  logic       fast_start,
  input  logic [2:0] osc_mode,
  input  logic       wake,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       pri_osc_en,
  output logic       rc_osc_en,
  output logic [2:0] osc_stat
);

  lpm_target_e target;
  logic        target_ok;
  lpm_state_e  state_q;
  logic        pri_rdy;
  logic        src_rdy;

  assign src_rdy = (clk_sel == SEL_SEC) ? sec_osc_run : pri_rdy;

  lpm_entry_decode u_entry (
    .idle_en    (idle_en),
    .clk_sel    (clk_sel),
    .sec_osc_en (sec_osc_en),
    .target     (target),
    .target_ok  (target_ok)
  );

  lpm_fsm #(
    .TCSD_CYCLES (TCSD_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .wake       (wake),
    .target     (target),
    .target_ok  (target_ok),
    .fast_start (fast_start),
    .src_rdy    (src_rdy),
    .state      (state_q)
  );

  lpm_startup_timer #(
    .OST_CYCLES (OST_CYCLES),
    .PLL_CYCLES (PLL_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_on   (pri_osc_en),
    .osc_mode (osc_mode),
    .ready    (pri_rdy)
  );

  lpm_gate_decode u_gate (
    .state       (state_q),
    .wdt_en      (wdt_en),
    .pri_rdy     (pri_rdy),
    .clk_sel     (clk_sel),
    .sec_osc_run (sec_osc_run),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .pri_osc_en  (pri_osc_en),
    .rc_osc_en   (rc_osc_en),
    .osc_stat    (osc_stat)
  );

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input lpm_state_e state,
  input logic       sleep_req,
  input logic       idle_en,
  input logic [1:0] clk_sel,
  input logic       sec_osc_en,
  input logic       wake,
  input logic       wdt_en,
  input logic       src_rdy,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       pri_osc_en,
  input logic       rc_osc_en,
  input logic [2:0] osc_stat
);

  a_r2_full_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP_FULL) |->
      (!cpu_clk_en && !per_clk_en && !pri_osc_en && osc_stat == 3'b000 &&
       rc_osc_en == wdt_en));

  a_r3_pidle_keeps_primary: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP_PIDLE) |-> (!cpu_clk_en && per_clk_en && pri_osc_en));

  a_r4_sidle_stops_primary: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP_SIDLE) |-> (!cpu_clk_en && per_clk_en && !pri_osc_en));

  a_r5_sidle_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && sleep_req && idle_en && clk_sel == 2'b01 && !sec_osc_en)
      |=> (state == ST_RUN));

  a_r6_cpu_held_in_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY) |-> !cpu_clk_en);

  a_r7_wait_for_source: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_SRC && !src_rdy) |=> (state == ST_WAIT_SRC && !cpu_clk_en));

  a_r8_fast_runs_on_rc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAST) |-> (cpu_clk_en && osc_stat[2] && rc_osc_en));

  a_r9_abort_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER && wake) |=> (state == ST_RUN && pri_osc_en));

  a_r10_wake_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && wake) |=> (state == ST_RUN));

  a_r11_stat_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(osc_stat[2:1]));

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state_q),
  .sleep_req  (sleep_req),
  .idle_en    (idle_en),
  .clk_sel    (clk_sel),
  .sec_osc_en (sec_osc_en),
  .wake       (wake),
  .wdt_en     (wdt_en),
  .src_rdy    (src_rdy),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .pri_osc_en (pri_osc_en),
  .rc_osc_en  (rc_osc_en),
  .osc_stat   (osc_stat)
);

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;

  localparam int OST  = 16;
  localparam int PLL  = 8;
  localparam int TCSD = 2;

  logic       clk;
  logic       rst_n;
  logic       sleep_req, idle_en, sec_osc_en, sec_osc_run, wdt_en, fast_start, wake;
  logic [1:0] clk_sel;
  logic [2:0] osc_mode;
  logic       cpu_clk_en, per_clk_en, pri_osc_en, rc_osc_en;
  logic [2:0] osc_stat;

  int nchk = 0;
  int nerr = 0;

  lpm_ctrl #(
    .OST_CYCLES  (OST),
    .PLL_CYCLES  (PLL),
    .TCSD_CYCLES (TCSD)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .idle_en     (idle_en),
    .clk_sel     (clk_sel),
    .sec_osc_en  (sec_osc_en),
    .sec_osc_run (sec_osc_run),
    .wdt_en      (wdt_en),
    .fast_start  (fast_start),
    .osc_mode    (osc_mode),
    .wake        (wake),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .pri_osc_en  (pri_osc_en),
    .rc_osc_en   (rc_osc_en),
    .osc_stat    (osc_stat)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int startup_len(input int m);
    if (m <= 2) return OST;
    if (m == 3) return OST + PLL;
    return 1;
  endfunction

  // sleep request on one edge (entry), target state after the next
  task automatic enter_sleep(input logic idle, input logic [1:0] sel);
    idle_en   = idle;
    clk_sel   = sel;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    step();
  endtask

  // wake sampled on edge e0; returns edges from e0 inclusive until cpu runs
  task automatic wake_measure(output int n);
    wake = 1'b1;
    step();
    wake = 1'b0;
    n = 1;
    while (!cpu_clk_en && n < 500) begin
      step();
      n++;
    end
  endtask

  task automatic fast_len(output int n);
    n = 1;
    while (osc_stat[2] && n < 500) begin
      step();
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; sleep_req = 1'b0; idle_en = 1'b0; clk_sel = 2'b00;
    sec_osc_en = 1'b0; sec_osc_run = 1'b0; wdt_en = 1'b0; fast_start = 1'b0;
    osc_mode = 3'd1; wake = 1'b0;
    settle(3);
    // R1 reset state
    chk("R1", "cpu_clk_en in reset", int'(cpu_clk_en), 1);
    chk("R1", "per_clk_en in reset", int'(per_clk_en), 1);
    chk("R1", "pri_osc_en in reset", int'(pri_osc_en), 1);
    chk("R1", "osc_stat in reset", int'(osc_stat), 0);
    rst_n = 1'b1;
    step();
    chk("R1", "osc_stat after release", int'(osc_stat), 0);
    chk("R1", "cpu_clk_en after release", int'(cpu_clk_en), 1);

    // R2, R7, R8: full sleep over every oscillator code, both start styles
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 2; f++) begin
        osc_mode   = 3'(m);
        wdt_en     = m[0];
        fast_start = 1'b0;
        settle(30);
        chk("R11", "primary ready bit in run", int'(osc_stat[0]), 1);
        idle_en   = 1'b0;
        clk_sel   = 2'b00;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R2", "cpu_clk_en in entry", int'(cpu_clk_en), 0);
        step();
        chk("R2", "cpu_clk_en full sleep", int'(cpu_clk_en), 0);
        chk("R2", "per_clk_en full sleep", int'(per_clk_en), 0);
        chk("R2", "pri_osc_en full sleep", int'(pri_osc_en), 0);
        chk("R2", "osc_stat full sleep", int'(osc_stat), 0);
        chk("R2", "rc_osc_en follows watchdog", int'(rc_osc_en), m % 2);
        settle(2);
        fast_start = 1'(f);
        wake_measure(n);
        if (f == 0) begin
          chk("R7", "edges to cpu run from full sleep", n, startup_len(m) + TCSD + 2);
        end else begin
          chk("R8", "edges to cpu run on fast start", n, 1);
          chk("R8", "internal clock status on fast start", int'(osc_stat[2]), 1);
          fast_len(n);
          chk("R8", "edges until internal status clears", n, startup_len(m) + 2);
        end
      end
    end
    fast_start = 1'b0;

    // R7, R8 with secondary source selected for full sleep
    sec_osc_run = 1'b1;
    for (int f = 0; f < 2; f++) begin
      settle(30);
      enter_sleep(1'b0, 2'b01);
      chk("R2", "osc_stat full sleep on secondary", int'(osc_stat), 0);
      step();
      fast_start = 1'(f);
      wake_measure(n);
      if (f == 0) chk("R7", "edges to run, secondary source", n, TCSD + 2);
      else begin
        chk("R8", "fast start on secondary select", n, 1);
        fast_len(n);
        chk("R8", "internal status with secondary ready", n, 2);
      end
    end
    fast_start = 1'b0;

    // R3, R6: primary idle for clock-select 00, 10, 11
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 4; s++) begin
        if (s == 1) continue;
        osc_mode = 3'(m);
        clk_sel  = 2'b00;
        settle(30);
        enter_sleep(1'b1, 2'(s));
        chk("R3", "cpu_clk_en primary idle", int'(cpu_clk_en), 0);
        chk("R3", "per_clk_en primary idle", int'(per_clk_en), 1);
        chk("R3", "pri_osc_en primary idle", int'(pri_osc_en), 1);
        chk("R3", "ready bit kept in primary idle", int'(osc_stat[0]), 1);
        settle(3);
        wake_measure(n);
        chk("R6", "edges to run from primary idle", n, TCSD + 1);
      end
    end

    // R4, R6, R11: secondary idle
    sec_osc_en = 1'b1;
    clk_sel    = 2'b01;
    settle(5);
    chk("R11", "secondary status in run", int'(osc_stat[1]), 1);
    enter_sleep(1'b1, 2'b01);
    chk("R4", "cpu_clk_en secondary idle", int'(cpu_clk_en), 0);
    chk("R4", "per_clk_en secondary idle", int'(per_clk_en), 1);
    chk("R4", "pri_osc_en secondary idle", int'(pri_osc_en), 0);
    chk("R4", "osc_stat secondary idle", int'(osc_stat), 2);
    settle(4);
    wake_measure(n);
    chk("R6", "edges to run from secondary idle", n, TCSD + 1);
    sec_osc_run = 1'b0;
    step();
    chk("R11", "secondary status with oscillator stopped", int'(osc_stat[1]), 0);

    // R5: secondary idle request with the oscillator disabled
    sec_osc_en = 1'b0;
    sec_osc_run = 1'b1;
    idle_en   = 1'b1;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R5", "cpu_clk_en after ignored request", int'(cpu_clk_en), 1);
    step();
    chk("R5", "cpu_clk_en one edge later", int'(cpu_clk_en), 1);
    chk("R5", "pri_osc_en unchanged", int'(pri_osc_en), 1);
    sec_osc_run = 1'b0;

    // R9: wake during entry
    clk_sel = 2'b00;
    idle_en = 1'b0;
    settle(30);
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R9", "cpu_clk_en in entry", int'(cpu_clk_en), 0);
    chk("R9", "pri_osc_en in entry", int'(pri_osc_en), 1);
    wake = 1'b1;
    step();
    wake = 1'b0;
    chk("R9", "cpu_clk_en after abort", int'(cpu_clk_en), 1);
    chk("R9", "pri_osc_en after abort", int'(pri_osc_en), 1);
    step();
    chk("R9", "per_clk_en after abort", int'(per_clk_en), 1);
    chk("R9", "primary ready kept after abort", int'(osc_stat[0]), 1);

    // R10: wake in run, and sleep sampled with wake
    wake = 1'b1;
    step();
    chk("R10", "cpu_clk_en with wake in run", int'(cpu_clk_en), 1);
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    wake = 1'b0;
    chk("R10", "cpu_clk_en with sleep and wake", int'(cpu_clk_en), 1);
    step();
    chk("R10", "cpu_clk_en one edge later", int'(cpu_clk_en), 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule